// File: doc/BRIEF.md
# Descriptor-Chained Copy Channel with Hardware Trigger

This block is a memory-to-memory copy channel that walks a chain of descriptors kept in a small table inside the block. Each table entry names a source address, a destination address, a word count and the index of the entry that follows it. Software loads the table and arms the channel at a starting entry. The channel then waits. Each pulse on the trigger input, normally the transfer-complete strobe of an upstream DMA channel, makes it copy exactly one entry.

A copy reads and writes words one at a time through a simple memory port, with both addresses counting upward. When the last word has been copied, the channel makes one more write: it stores a programmed mask value at a programmed clear-register address. This write clears the upstream request, so no processor has to step in between entries. The chain stops when an entry's successor index is the reserved null value. If the last entry points back to an earlier entry, the chain runs forever and only an abort stops it.

The memory port is a single word-wide port with no wait states. A read returns its data in the cycle after it is issued.

Top module: `trig_chain_dma`

## Requirements
- R1: After reset the channel is idle. `busy`, `done`, `eol` and `mem_req` are all low.
- R2: While `busy` is low, a pulse on `arm` selects entry `arm_idx`, raises `busy` and clears `eol`. The channel then makes no memory access until `trig` is seen.
- R3: A trigger copies the current entry, word by word, for k = 0 to len-1. Each word takes one cycle to read address src+k and the next cycle to write that data to address dst+k. An entry with len = 0 copies nothing.
- R4: After the data words of an entry, the channel makes exactly one write of `clr_mask` to `clr_addr`. `done` is high during that write cycle.
- R5: The successor value all-ones (15 with the default 4-bit index) means null. Finishing an entry whose successor is null sets `eol` and drops `busy`. `eol` stays set until the next arm.
- R6: Finishing an entry whose successor is not null makes the successor the current entry. The channel then waits for the next trigger without copying it.
- R7: A chain whose last entry points back to an earlier entry keeps copying on every trigger. It never sets `eol` and never drops `busy`.
- R8: A trigger that arrives while an entry is being copied is held as pending. The successor entry then starts in the cycle right after the clear write, with no new trigger needed.
- R9: `abort` returns the channel to idle in the next cycle and discards a pending trigger. Later triggers cause no memory access until the channel is armed again.
- R10: A pulse on `desc_we` stores the four descriptor fields into table entry `desc_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_idx | input | PW | Table entry to write |
| desc_src | input | AW | Source start address |
| desc_dst | input | AW | Destination start address |
| desc_len | input | LW | Word count |
| desc_next | input | PW | Successor index, all-ones = null |
| clr_addr | input | AW | Address of the upstream clear register |
| clr_mask | input | DW | Value written to clear the upstream request |
| arm | input | 1 | Arm the channel at `arm_idx` |
| arm_idx | input | PW | Starting entry |
| trig | input | 1 | Upstream transfer-complete pulse |
| abort | input | 1 | Stop the channel and drop pending work |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |
| busy | output | 1 | Channel armed or copying |
| done | output | 1 | Entry finished, clear write in progress |
| eol | output | 1 | Chain ended at a null successor |

## Verification
The assertions assume that the table is not rewritten while the entry it holds is in use. They also assume that `mem_rdata` always answers a read in the next cycle. The bench loads every descriptor while the channel is idle or waiting, and its memory model registers read data on the same edge that ends the read cycle. Word counts are kept small enough that the source and destination windows never overlap, so every copied word can be compared with its untouched source.

// File: rtl/trig_chain_dma.sv
module trig_chain_dma #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we,
  input  logic [PW-1:0] desc_idx,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_dst,
  input  logic [LW-1:0] desc_len,
  input  logic [PW-1:0] desc_next,
  input  logic [AW-1:0] clr_addr,
  input  logic [DW-1:0] clr_mask,
  input  logic          arm,
  input  logic [PW-1:0] arm_idx,
  input  logic          trig,
  input  logic          abort,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          eol
);
  localparam int NODES = 1 << PW;
  localparam logic [PW-1:0] NULLP = {PW{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_WR, S_ACK} st_t;

  logic [AW-1:0] t_src  [NODES];
  logic [AW-1:0] t_dst  [NODES];
  logic [LW-1:0] t_len  [NODES];
  logic [PW-1:0] t_next [NODES];

  st_t           st;
  logic [PW-1:0] cur;
  logic [LW-1:0] idx;
  logic          pend;
  logic          eol_q;

  always_ff @(posedge clk)
    if (desc_we) begin
      t_src[desc_idx]  <= desc_src;
      t_dst[desc_idx]  <= desc_dst;
      t_len[desc_idx]  <= desc_len;
      t_next[desc_idx] <= desc_next;
    end

  wire [PW-1:0] nxt      = t_next[cur];
  wire          last_wd  = ({1'b0, idx} + 1'b1) == {1'b0, t_len[cur]};
  wire          go_next  = pend || trig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      cur   <= '0;
      idx   <= '0;
      pend  <= 1'b0;
      eol_q <= 1'b0;
    end else if (abort) begin
      st   <= S_IDLE;
      pend <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (arm) begin
          st    <= S_WAIT;
          cur   <= arm_idx;
          eol_q <= 1'b0;
        end
        S_WAIT: if (trig) begin
          idx <= '0;
          st  <= (t_len[cur] == '0) ? S_ACK : S_RD;
        end
        S_RD: begin
          if (trig) pend <= 1'b1;
          st <= S_WR;
        end
        S_WR: begin
          if (trig) pend <= 1'b1;
          idx <= idx + 1'b1;
          st  <= last_wd ? S_ACK : S_RD;
        end
        S_ACK: begin
          pend <= 1'b0;
          idx  <= '0;
          if (nxt == NULLP) begin
            st    <= S_IDLE;
            eol_q <= 1'b1;
          end else begin
            cur <= nxt;
            if (go_next) st <= (t_len[nxt] == '0) ? S_ACK : S_RD;
            else         st <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  assign busy      = st != S_IDLE;
  assign done      = st == S_ACK;
  assign eol       = eol_q;
  assign mem_req   = st == S_RD || st == S_WR || st == S_ACK;
  assign mem_we    = st == S_WR || st == S_ACK;
  assign mem_addr  = (st == S_RD) ? t_src[cur] + AW'(idx) :
                     (st == S_WR) ? t_dst[cur] + AW'(idx) : clr_addr;
  assign mem_wdata = (st == S_ACK) ? clr_mask : mem_rdata;

  a_r5_eol_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> !busy);
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !mem_req);
  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm));
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |-> idx < t_len[cur]);
  a_r8_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pend && nxt != NULLP && !abort) |=> mem_req);
  a_r4_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort) |=> !done || $past(t_len[nxt]) == '0);
endmodule

// File: tb/tb_trig_chain_dma.sv
module tb_trig_chain_dma;
  localparam int CLK_P = 10;
  localparam logic [15:0] CLR_A = 16'h4000;
  localparam logic [31:0] CLR_M = 32'h0000_0020;
  localparam logic [3:0]  NUL = 4'hF;

  logic clk = 0, rst_n = 0;
  logic desc_we = 0, arm = 0, trig = 0, abort = 0;
  logic [3:0] desc_idx = 0, desc_next = 0, arm_idx = 0;
  logic [15:0] desc_src = 0, desc_dst = 0;
  logic [7:0] desc_len = 0;
  logic mem_req, mem_we, busy, done, eol;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  trig_chain_dma dut (.clk, .rst_n, .desc_we, .desc_idx, .desc_src, .desc_dst,
    .desc_len, .desc_next, .clr_addr(CLR_A), .clr_mask(CLR_M), .arm, .arm_idx,
    .trig, .abort, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .busy, .done, .eol);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, acks = 0, wrs = 0, dones = 0;
  bit finished = 0;
  logic [31:0] mem [256];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? (i * 32'h0101_0101) ^ 32'hA5 : 32'h0;

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_req && mem_we) begin
      wrs++;
      if (mem_addr == CLR_A) begin
        acks++;
        chk(mem_wdata == CLR_M, "R4 clear value", mem_wdata, CLR_M);
      end else mem[mem_addr[7:0]] <= mem_wdata;
    end
    if (done) dones++;
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [3:0] i, input logic [15:0] s, input logic [15:0] d,
                      input logic [7:0] l, input logic [3:0] nx);
    desc_we = 1; desc_idx = i; desc_src = s; desc_dst = d; desc_len = l; desc_next = nx;
    tick(); desc_we = 0;
  endtask

  task automatic do_arm(input logic [3:0] i);
    arm = 1; arm_idx = i; tick(); arm = 0;
  endtask
  task automatic pulse_trig; trig = 1; tick(); trig = 0; endtask
  task automatic pulse_abort; abort = 1; tick(); abort = 0; endtask

  task automatic wait_dones(input int target, input string tag);
    int n = 0;
    while (dones < target && n < 2000) begin tick(); n++; end
    chk(dones >= target, tag, dones, target);
  endtask

  task automatic chk_copy(input int s, input int d, input int l, input string tag);
    for (int k = 0; k < l; k++) chk(mem[d+k] == mem[s+k], tag, mem[d+k], mem[s+k]);
  endtask

  initial begin
    int a0, w0;
    tick(3); rst_n = 1; tick();
    chk({busy, done, eol, mem_req} == 4'b0, "R1 reset outputs", {busy, done, eol, mem_req}, 0);

    for (int L = 0; L < 7; L++) begin
      load(0, 16'(L*8), 16'(128 + L*8), 8'(L), NUL); // R10 table load
      do_arm(0);
      chk(busy && !eol, "R2 armed", {busy, eol}, 2'b10);
      w0 = wrs; a0 = acks;
      tick(5);
      chk(wrs == w0, "R2 quiet while waiting", wrs, w0);
      pulse_trig();
      wait_dones(dones + 1, "R4 done pulse");
      tick();
      chk(acks == a0 + 1, "R4 single clear write", acks, a0 + 1);
      chk(wrs == w0 + L + 1, "R3 word writes", wrs, w0 + L + 1);
      chk_copy(L*8, 128 + L*8, L, "R3 copy");
      if (L == 0) chk(mem[128] == 0, "R3 zero length", mem[128], 0);
      chk(eol && !busy, "R5 end of list", {eol, busy}, 2'b10);
    end

    load(1, 16'h40, 16'hC0, 2, 2); load(2, 16'h48, 16'hC8, 3, 3); load(3, 16'h50, 16'hD0, 1, NUL);
    do_arm(1);
    pulse_trig(); wait_dones(dones + 1, "R6 node one"); tick(3);
    chk(busy && !eol, "R6 waits at successor", {busy, eol}, 2'b10);
    chk(mem[8'hC8] == 0, "R6 successor not copied", mem[8'hC8], 0);
    pulse_trig(); wait_dones(dones + 1, "R6 node two");
    pulse_trig(); wait_dones(dones + 1, "R6 node three"); tick();
    chk_copy(16'h40, 16'hC0, 2, "R3 chain copy a");
    chk_copy(16'h48, 16'hC8, 3, "R3 chain copy b");
    chk_copy(16'h50, 16'hD0, 1, "R3 chain copy c");
    chk(eol && !busy, "R5 chain end", {eol, busy}, 2'b10);

    load(4, 16'h20, 16'hE0, 4, 5); load(5, 16'h28, 16'hE8, 2, NUL);
    do_arm(4);
    a0 = dones;
    pulse_trig(); tick(); pulse_trig();
    wait_dones(a0 + 2, "R8 pending trigger served"); tick();
    chk_copy(16'h20, 16'hE0, 4, "R8 copy first");
    chk_copy(16'h28, 16'hE8, 2, "R8 copy second");
    chk(eol, "R8 chain ended", eol, 1);

    load(6, 16'h30, 16'hF0, 2, 7); load(7, 16'h38, 16'hF4, 2, 6);
    do_arm(6);
    a0 = acks;
    for (int t = 0; t < 5; t++) begin
      pulse_trig(); wait_dones(dones + 1, "R7 loop node"); tick();
      chk(busy && !eol, "R7 circular keeps running", {busy, eol}, 2'b10);
    end
    chk(acks == a0 + 5, "R7 clear per node", acks, a0 + 5);
    chk_copy(16'h30, 16'hF0, 2, "R7 copy");

    pulse_abort();
    chk(!busy, "R9 abort idles", busy, 0);
    a0 = acks; w0 = wrs;
    pulse_trig(); tick(10);
    chk(wrs == w0, "R9 trigger ignored after abort", wrs, w0);

    load(0, 16'h00, 16'h80, 6, NUL);
    do_arm(0);
    pulse_trig(); tick(); pulse_trig(); tick(); pulse_abort();
    w0 = wrs; tick(20);
    chk(wrs == w0 && !busy, "R9 abort mid node", wrs, w0);
    do_arm(0); tick(10);
    chk(wrs == w0, "R9 pending dropped", wrs, w0);
    pulse_abort();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule